// File: doc/BRIEF.md
# Muxed Interrupt Vector Router

This block takes level events from seven interrupt inputs and routes them through six vector registers. Each vector register carries a destination server number, a priority, a source number and a pending flag. An event names an input and a new level. The block records that level in a per-input status bit. It then drives one of eight level-sensitive output lines, chosen by the vector's source field. Finally it recomputes the vector's pending flag.

Inputs 0 and 1 share vector 0. The line behind that vector falls only once both of those inputs are low. A priority of all ones masks a vector: it can never show pending. A register write port updates the server, priority and source fields of a vector. For every accepted write, the block hands a decoded server/priority/source triple to a downstream presenter. The decoded server drops the two link-pointer bits of the server field.

A combinational read port returns the packed contents of any vector. Two status words expose the per-input status bits at fixed positions.

Top module: `ivr_router`

## Requirements
- R1: After synchronous reset, vector v (0..5) reads priority 8'hFF, source v, server 0 and pending 0. All eight lines and both status words are zero.
- R2: Input 0 maps to `ctl_stat` bit 47 and input 1 to bit 46, and both use vector 0. Inputs 2..6 map to `aux_stat` bits 36..32 and use vectors 1..5. Each status bit holds the last level given to its input.
- R3: A raising event sets, on the next clock, the line numbered by the vector's source field. It sets the vector's pending flag only if its priority is not 8'hFF.
- R4: A lowering event on inputs 2..6 clears that line and the vector's pending flag on the next clock.
- R5: A lowering event on input 0 or 1 keeps the vector-0 line high, and pending equal to "not masked", while the other shared input is still high. The line and pending clear only once both are low.
- R6: A vector write replaces server (bits 55:40), priority (bits 39:32) and source (bits 31:29) and keeps the pending flag (bit 24). Writing priority 8'hFF clears pending.
- R7: A write to vectors 0..5 with a source below 6 pulses `dn_valid` for one cycle on the next clock. It carries `dn_server` = server field bits 15:2, plus `dn_prio` and `dn_src`.
- R8: A write whose source field is 6 or 7 is stored but not forwarded. `dn_valid` stays low and `err_o` pulses on the next clock.
- R9: An event naming input 7 changes no status bit, line or vector, and pulses `err_o` on the next clock.
- R10: When a write and an event hit the same vector in one cycle, the event uses the newly written source and priority.
- R11: `rd_data` shows vector `rd_vec` with all unlisted bits zero. Vector indices 6 and 7 read all ones, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Input level event strobe |
| ev_idx | input | 3 | Input number of the event |
| ev_level | input | 1 | New level of that input |
| wr_en | input | 1 | Vector write strobe |
| wr_vec | input | 3 | Vector index written |
| wr_data | input | 64 | Write data in vector layout |
| rd_vec | input | 3 | Vector index read |
| rd_data | output | 64 | Packed vector contents |
| ctl_stat | output | 64 | Status word of the shared inputs |
| aux_stat | output | 64 | Status word of the other inputs |
| lines_o | output | 8 | Level output line per source number |
| dn_valid | output | 1 | Downstream update pulse |
| dn_server | output | 14 | Decoded server number |
| dn_prio | output | 8 | Priority sent downstream |
| dn_src | output | 3 | Source sent downstream |
| err_o | output | 1 | Pulse on bad input index or rejected source |

## Verification
A vector write and an input event can land on the same vector in the same clock cycle. The bench provokes this by writing a vector with a new source and an unmasking priority while, in that cycle, raising an input routed to it. The outcome is judged by which line rises and by the pending flag. Both must follow the freshly written fields, not the old ones.

The bench also lowers one shared input while the other stays high, in sequence with a masked and an unmasked priority. This shows that line hold and pending follow the mask.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int IDX_W      = 3;
    localparam int NUM_IN     = 7;
    localparam int NUM_VEC    = 6;
    localparam int NUM_SHARED = 2;
    localparam int SRC_W      = 3;
    localparam int NUM_LINES  = 1 << SRC_W;
    localparam int SERVER_W   = 16;
    localparam int PRIO_W     = 8;
    localparam int LINK_W     = 2;
    localparam int DN_SRV_W   = SERVER_W - LINK_W;
    localparam int DATA_W     = 64;
    localparam int SERVER_LO  = 40;
    localparam int PRIO_LO    = 32;
    localparam int SRC_LO     = 29;
    localparam int PEND_POS   = 24;
    localparam int SHARED_TOP = 47;
    localparam int AUX_TOP    = 36;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [SRC_W-1:0] src_t;

    typedef struct packed {
        logic [SERVER_W-1:0] server;
        logic [PRIO_W-1:0]   prio;
        src_t                src;
        logic                pend;
    } vec_t;

    function automatic idx_t vec_of_input(idx_t i);
        if (int'(i) < NUM_SHARED) return '0;
        return idx_t'(int'(i) - NUM_SHARED + 1);
    endfunction

    function automatic logic prio_masked(logic [PRIO_W-1:0] p);
        return &p;
    endfunction

    function automatic logic src_ok(src_t s);
        return int'(s) < NUM_VEC;
    endfunction

    function automatic logic [DATA_W-1:0] pack_vec(vec_t v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[SERVER_LO +: SERVER_W] = v.server;
        r[PRIO_LO +: PRIO_W]     = v.prio;
        r[SRC_LO +: SRC_W]       = v.src;
        r[PEND_POS]              = v.pend;
        return r;
    endfunction
endpackage

// File: rtl/ivr_status.sv
module ivr_status
    import ivr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_fire,
    input  idx_t              ev_idx,
    input  logic              ev_level,
    output logic [NUM_IN-1:0] stat,
    output logic              ev_state
);
    logic [NUM_IN-1:0] stat_q;
    logic [NUM_IN-1:0] stat_nxt;

    always_comb begin
        stat_nxt = stat_q;
        for (int k = 0; k < NUM_IN; k++) begin
            if (ev_fire && int'(ev_idx) == k) stat_nxt[k] = ev_level;
        end
        if (int'(ev_idx) < NUM_SHARED) ev_state = |stat_nxt[NUM_SHARED-1:0];
        else                           ev_state = ev_level;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_nxt;
    end

    assign stat = stat_q;

    p_status_follows_r2: assert property (@(posedge clk) disable iff (rst)
        ev_fire |=> stat_q[$past(ev_idx)] == $past(ev_level));
endmodule

// File: rtl/ivr_vector_file.sv
module ivr_vector_file
    import ivr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  idx_t                wr_vec,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                ev_fire,
    input  idx_t                ev_vec,
    input  logic                ev_state,
    output vec_t [NUM_VEC-1:0]  vecs,
    output src_t                ev_src
);
    vec_t [NUM_VEC-1:0] vec_q;
    vec_t [NUM_VEC-1:0] vec_eff;

    wire unused_wr_bits = ^{wr_data[DATA_W-1:SERVER_LO+SERVER_W], wr_data[SRC_LO-1:0]};

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        always_comb begin
            vec_eff[v] = vec_q[v];
            if (wr_en && int'(wr_vec) == v) begin
                vec_eff[v].server = wr_data[SERVER_LO +: SERVER_W];
                vec_eff[v].prio   = wr_data[PRIO_LO +: PRIO_W];
                vec_eff[v].src    = wr_data[SRC_LO +: SRC_W];
                if (prio_masked(vec_eff[v].prio)) vec_eff[v].pend = 1'b0;
            end
            if (ev_fire && int'(ev_vec) == v)
                vec_eff[v].pend = ev_state && !prio_masked(vec_eff[v].prio);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                vec_q[v].server <= '0;
                vec_q[v].prio   <= '1;
                vec_q[v].src    <= src_t'(v);
                vec_q[v].pend   <= 1'b0;
            end else begin
                vec_q[v] <= vec_eff[v];
            end
        end

        p_mask_no_pending_r6: assert property (@(posedge clk) disable iff (rst)
            prio_masked(vec_q[v].prio) |-> !vec_q[v].pend);
    end

    always_comb begin
        ev_src = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (int'(ev_vec) == v) ev_src = vec_eff[v].src;
        end
    end

    assign vecs = vec_q;
endmodule

// File: rtl/ivr_line_drv.sv
module ivr_line_drv
    import ivr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ev_fire,
    input  src_t                 ev_src,
    input  logic                 ev_state,
    output logic [NUM_LINES-1:0] lines
);
    logic [NUM_LINES-1:0] lines_q;

    always_ff @(posedge clk) begin
        if (rst)          lines_q <= '0;
        else if (ev_fire) lines_q[ev_src] <= ev_state;
    end

    assign lines = lines_q;

    p_line_update_r3: assert property (@(posedge clk) disable iff (rst)
        ev_fire |=> lines_q[$past(ev_src)] == $past(ev_state));
endmodule

// File: rtl/ivr_router.sv
module ivr_router
    import ivr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         ev_valid,
    input  logic [2:0]   ev_idx,
    input  logic         ev_level,
    input  logic         wr_en,
    input  logic [2:0]   wr_vec,
    input  logic [63:0]  wr_data,
    input  logic [2:0]   rd_vec,
    output logic [63:0]  rd_data,
    output logic [63:0]  ctl_stat,
    output logic [63:0]  aux_stat,
    output logic [7:0]   lines_o,
    output logic         dn_valid,
    output logic [13:0]  dn_server,
    output logic [7:0]   dn_prio,
    output logic [2:0]   dn_src,
    output logic         err_o
);
    logic               ev_fire, wr_ok, ev_state;
    idx_t               ev_vec;
    src_t               ev_src, wr_src;
    logic [NUM_IN-1:0]  stat;
    vec_t [NUM_VEC-1:0] vecs;

    assign ev_fire = ev_valid && (int'(ev_idx) < NUM_IN);
    assign ev_vec  = vec_of_input(ev_idx);
    assign wr_ok   = wr_en && (int'(wr_vec) < NUM_VEC);
    assign wr_src  = wr_data[SRC_LO +: SRC_W];

    ivr_status u_status (
        .clk(clk), .rst(rst), .ev_fire(ev_fire), .ev_idx(ev_idx),
        .ev_level(ev_level), .stat(stat), .ev_state(ev_state)
    );

    ivr_vector_file u_vecs (
        .clk(clk), .rst(rst), .wr_en(wr_ok), .wr_vec(wr_vec), .wr_data(wr_data),
        .ev_fire(ev_fire), .ev_vec(ev_vec), .ev_state(ev_state),
        .vecs(vecs), .ev_src(ev_src)
    );

    ivr_line_drv u_lines (
        .clk(clk), .rst(rst), .ev_fire(ev_fire), .ev_src(ev_src),
        .ev_state(ev_state), .lines(lines_o)
    );

    always_comb begin
        rd_data = '1;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (int'(rd_vec) == v) rd_data = pack_vec(vecs[v]);
        end
        ctl_stat = '0;
        aux_stat = '0;
        for (int k = 0; k < NUM_SHARED; k++) ctl_stat[SHARED_TOP-k] = stat[k];
        for (int k = 0; k < NUM_IN-NUM_SHARED; k++) aux_stat[AUX_TOP-k] = stat[NUM_SHARED+k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid  <= 1'b0;
            dn_server <= '0;
            dn_prio   <= '0;
            dn_src    <= '0;
            err_o     <= 1'b0;
        end else begin
            dn_valid <= wr_ok && src_ok(wr_src);
            err_o    <= (ev_valid && !ev_fire) || (wr_ok && !src_ok(wr_src));
            if (wr_ok && src_ok(wr_src)) begin
                dn_server <= wr_data[SERVER_LO+LINK_W +: DN_SRV_W];
                dn_prio   <= wr_data[PRIO_LO +: PRIO_W];
                dn_src    <= wr_src;
            end
        end
    end

    logic shared_other;
    assign shared_other = ev_idx[0] ? stat[0] : stat[1];

    p_shared_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_fire && int'(ev_idx) < NUM_SHARED && !ev_level && shared_other)
        |=> lines_o[$past(ev_src)]);
    p_bad_idx_err_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !ev_fire) |=> err_o);
    p_dn_src_ok_r7: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> src_ok(dn_src));
    p_dn_server_r7: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> dn_server == $past(wr_data[SERVER_LO+LINK_W +: DN_SRV_W]));
    p_reject_no_fwd_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && !src_ok(wr_src)) |=> (err_o && !dn_valid));
endmodule

// File: tb/tb_ivr_router.sv
module tb_ivr_router;
    logic clk = 0, rst = 1;
    logic ev_valid = 0, ev_level = 0, wr_en = 0;
    logic [2:0] ev_idx = 0, wr_vec = 0, rd_vec = 0;
    logic [63:0] wr_data = 0;
    logic [63:0] rd_data, ctl_stat, aux_stat;
    logic [7:0] lines_o, dn_prio;
    logic dn_valid, err_o;
    logic [13:0] dn_server;
    logic [2:0] dn_src;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [15:0] m_srv [6];
    logic [7:0]  m_pri [6];
    logic [2:0]  m_src [6];
    logic        m_pend[6];
    logic [6:0]  m_stat;
    logic [7:0]  m_lines;

    always #10 clk = ~clk;

    ivr_router dut (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] vdata(int srv, int pri, int src);
        logic [63:0] d = '0;
        d[55:40] = 16'(srv); d[39:32] = 8'(pri); d[31:29] = 3'(src);
        return d;
    endfunction

    task automatic check_state(string req);
        logic [63:0] exp_ctl, exp_aux;
        for (int v = 0; v < 8; v++) begin
            rd_vec = 3'(v);
            #1;
            if (v < 6) begin
                logic [63:0] e = vdata(m_srv[v], m_pri[v], m_src[v]);
                e[24] = m_pend[v];
                chk(req, rd_data, e);
            end else chk({req, " R11"}, rd_data, '1);
        end
        exp_ctl = '0; exp_aux = '0;
        exp_ctl[47] = m_stat[0]; exp_ctl[46] = m_stat[1];
        for (int k = 0; k < 5; k++) exp_aux[36-k] = m_stat[2+k];
        chk({req, " R2 ctl"}, ctl_stat, exp_ctl);
        chk({req, " R2 aux"}, aux_stat, exp_aux);
        chk({req, " lines"}, 64'(lines_o), 64'(m_lines));
    endtask

    // one clock of stimulus; write is applied to the model before the event (R10)
    task automatic step(string req, bit de, int ei, bit lvl, bit dw, int wv, logic [63:0] wd);
        bit exp_dn, exp_err;
        @(negedge clk);
        ev_valid = de; ev_idx = 3'(ei); ev_level = lvl;
        wr_en = dw; wr_vec = 3'(wv); wr_data = wd;
        exp_dn = 0; exp_err = 0;
        if (dw && wv < 6) begin
            m_srv[wv] = wd[55:40]; m_pri[wv] = wd[39:32]; m_src[wv] = wd[31:29];
            if (wd[39:32] == 8'hFF) m_pend[wv] = 0;
            exp_dn = wd[31:29] < 6;
            exp_err = !exp_dn;
        end
        if (de && ei > 6) exp_err = 1;
        if (de && ei < 7) begin
            int v = (ei < 2) ? 0 : ei - 1;
            bit st;
            m_stat[ei] = lvl;
            st = (ei < 2) ? (m_stat[0] | m_stat[1]) : lvl;
            m_lines[m_src[v]] = st;
            m_pend[v] = st && (m_pri[v] != 8'hFF);
        end
        @(negedge clk);
        chk({req, " dn_valid"}, 64'(dn_valid), 64'(exp_dn));
        chk({req, " err"}, 64'(err_o), 64'(exp_err));
        if (exp_dn) begin
            chk({req, " R7 server"}, 64'(dn_server), 64'(wd[55:42]));
            chk({req, " R7 prio"}, 64'(dn_prio), 64'(wd[39:32]));
            chk({req, " R7 src"}, 64'(dn_src), 64'(wd[31:29]));
        end
        ev_valid = 0; wr_en = 0;
        check_state(req);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < 6; v++) begin
            m_srv[v] = 0; m_pri[v] = 8'hFF; m_src[v] = 3'(v); m_pend[v] = 0;
        end
        m_stat = 0; m_lines = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 dn_valid", 64'(dn_valid), 0);
        chk("R1 err", 64'(err_o), 0);
        check_state("R1");

        // R3 R4 R2: unmasked sweep over every input
        for (int i = 0; i < 7; i++) begin
            int v = (i < 2) ? 0 : i - 1;
            step("R7 unmask", 0, 0, 0, 1, v, vdata(16'h1230 + i * 7, i + 1, v));
            step("R3 raise", 1, i, 1, 0, 0, 0);
            step("R4 lower", 1, i, 0, 0, 0, 0);
        end
        // R3: masked raise sets line, never pending
        for (int i = 0; i < 7; i++) begin
            int v = (i < 2) ? 0 : i - 1;
            step("R6 mask", 0, 0, 0, 1, v, vdata(16'h00F3 + i, 8'hFF, v));
            step("R3 masked raise", 1, i, 1, 0, 0, 0);
            step("R4 lower", 1, i, 0, 0, 0, 0);
        end
        // R5: shared inputs, masked then unmasked
        for (int p = 0; p < 2; p++) begin
            step("R6 prio", 0, 0, 0, 1, 0, vdata(16'h0F0F, p ? 8'h07 : 8'hFF, 0));
            step("R5 raise0", 1, 0, 1, 0, 0, 0);
            step("R5 raise1", 1, 1, 1, 0, 0, 0);
            step("R5 lower0 hold", 1, 0, 0, 0, 0, 0);
            step("R5 raise0 again", 1, 0, 1, 0, 0, 0);
            step("R5 lower1 hold", 1, 1, 0, 0, 0, 0);
            step("R5 lower0 drop", 1, 0, 0, 0, 0, 0);
        end
        // R6: pending kept across write, cleared by mask
        step("R6 unmask", 0, 0, 0, 1, 1, vdata(16'h4444, 3, 1));
        step("R6 raise", 1, 2, 1, 0, 0, 0);
        step("R6 keep pend", 0, 0, 0, 1, 1, vdata(16'hABCD, 5, 1));
        step("R6 mask clears", 0, 0, 0, 1, 1, vdata(16'hABCD, 8'hFF, 1));
        step("R6 unmask no pend", 0, 0, 0, 1, 1, vdata(16'hABCD, 5, 1));
        step("R4 lower", 1, 2, 0, 0, 0, 0);
        // R8 R7: source sweep on vector 3
        for (int s = 0; s < 8; s++) step("R8 src sweep", 0, 0, 0, 1, 3, vdata(16'hFFFF - s, 9 + s, s));
        step("R8 raise via src7", 1, 4, 1, 0, 0, 0);
        step("R8 lower", 1, 4, 0, 0, 0, 0);
        step("R8 restore", 0, 0, 0, 1, 3, vdata(0, 8'hFF, 3));
        // R9: bad index, both levels
        step("R9 bad idx hi", 1, 7, 1, 0, 0, 0);
        step("R9 bad idx lo", 1, 7, 0, 0, 0, 0);
        // R11: writes to absent vectors
        step("R11 write v6", 0, 0, 0, 1, 6, vdata(16'h1111, 1, 1));
        step("R11 write v7", 0, 0, 0, 1, 7, vdata(16'h2222, 2, 2));
        // R10: same-cycle write and event on one vector
        step("R10 write+raise", 1, 3, 1, 1, 2, vdata(16'h0808, 1, 5));
        step("R10 write+lower masked", 1, 3, 0, 1, 2, vdata(16'h0808, 8'hFF, 0));
        step("R10 write+raise src2", 1, 3, 1, 1, 2, vdata(16'h0101, 4, 2));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule